// File: doc/BRIEF.md
# USB Transmit Line Encoder

This block turns bytes from a controlling unit into a stream of USB line symbols (J, K and SE0) together with a drive-enable for the line drivers. In its normal mode it inserts a stuffed zero after a run of ones, applies NRZI coding and closes every packet with an end-of-packet pattern. A two-bit mode input can instead release the line (non-driving) or bypass both stuffing and NRZI so that each data bit becomes one line symbol directly. A speed input picks the bit period, so one core clock serves both high-speed and full-speed signalling through a symbol-rate enable.

A packet begins with a one-cycle `txStart` while the block is idle. From then on the block asks for each byte with a single-cycle `inReady` at the moment it needs it. A byte moves when `inValid` and `inReady` are both high. If `inReady` is raised and `inValid` is low, the packet is over. Line symbols are coded on two bits as {`lineDp`,`lineDm`}: J = 2'b10, K = 2'b01, SE0 = 2'b00.

Top module: `usbTxEncoder`

## Requirements
- R1: While `rst` is high, `driveEn`, `lineDp`, `lineDm` and `inReady` are all 0.
- R2: In mode 2'b00 the first symbol of a packet is coded against an idle level of J. A data bit 1 repeats the previous symbol and a data bit 0 switches between J (2'b10) and K (2'b01).
- R3: In mode 2'b00, after six consecutive data ones a stuffed zero (one extra level toggle) is sent before the next bit or the end of packet. The stuffed bit takes no input bit, and `inReady` stays low during its symbol slot.
- R4: Bytes are sent least significant bit first. `inReady` is high for one cycle per byte needed, and the byte is taken at the clock edge where `inValid` and `inReady` are both high.
- R5: In mode 2'b00, when a byte is requested and `inValid` is low, the block sends two SE0 symbols and then one J, and holds J while idle afterwards.
- R6: In mode 2'b10 each data bit is sent as one symbol, 1 as J and 0 as K, with no stuffing. A packet ends with a single J and no SE0.
- R7: In modes 2'b01 and 2'b11, `driveEn` is 0, both line outputs are 0, `txStart` is ignored and `inReady` stays 0.
- R8: A change on `opMode` takes effect at the next clock edge. It abandons any packet in progress, and the block then waits idle on J with no further byte requests when the new mode drives the line.
- R9: With `speedSel` = 0 each symbol lasts HS_DIV clocks, and with `speedSel` = 1 it lasts FS_DIV clocks, in every mode. The first symbol of a packet appears one bit period after the clock edge that accepted `txStart`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | DATA_W | Byte offered by the controlling unit |
| inValid | input | 1 | `inData` holds a byte for the current packet |
| inReady | output | 1 | Block takes a byte at this edge if `inValid` is high |
| txStart | input | 1 | One-cycle request to begin a packet while idle |
| opMode | input | 2 | 00 normal, 01 non-driving, 10 raw bits, 11 treated as non-driving |
| speedSel | input | 1 | 0 high speed (HS_DIV clocks per bit), 1 full speed (FS_DIV clocks per bit) |
| lineDp | output | 1 | Plus line level of the current symbol |
| lineDm | output | 1 | Minus line level of the current symbol |
| driveEn | output | 1 | Line drivers enabled |

## Verification
Normal-mode packets use an all-zero byte, where every bit toggles the line, and an alternating byte. They also include a run of ones across a byte boundary, where a misplaced stuff bit shifts every later symbol, and a byte whose last six bits are ones, which shows whether the stuff comes before the end-of-packet. Raw mode is driven with long runs of ones that normal mode would stuff, so any stuffing or NRZI leaking into it is visible. The same patterns at full speed sample only on the expected symbol boundaries, so a wrong bit period misaligns the stream. Mode switches in the middle of a packet and the two non-driving codes show whether the line is released at once and whether the abandoned packet resumes.

// File: rtl/usbTxPkg.sv
package usbTxPkg;

  // Line symbol codes, {plus, minus}
  localparam logic [1:0] SYM_SE0 = 2'b00;
  localparam logic [1:0] SYM_K   = 2'b01;
  localparam logic [1:0] SYM_J   = 2'b10;

  // Operating mode codes
  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_OFF    = 2'b01;
  localparam logic [1:0] MODE_RAW    = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic arm;        // packet accepted, reset coding state
    logic loadByte;   // take inData and send its bit 0
    logic emitData;   // send next bit of the shift register
    logic emitStuff;  // send stuffed zero
    logic emitSe0;    // send SE0
    logic emitJ;      // send J and return level to idle
    logic abort;      // mode changed, drop everything
    logic rawMode;    // bypass stuffing and NRZI
  } txStrobe_t;

endpackage

// File: rtl/usbTxCtrl.sv
module usbTxCtrl
  import usbTxPkg::*;
#(
  parameter int HS_DIV  = 1,
  parameter int FS_DIV  = 4,
  parameter int EOP_SE0 = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      txStart,
  input  logic      inValid,
  input  logic [1:0] opMode,
  input  logic      speedSel,
  input  logic      bitsDone,
  input  logic      stuffDue,
  output logic      inReady,
  output logic      driveEn,
  output logic      symTick,
  output txStrobe_t strobe
);

  localparam int MAX_DIV = (FS_DIV > HS_DIV) ? FS_DIV : HS_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int EOP_W   = $clog2(EOP_SE0 + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_EOP} state_e;

  state_e            state;
  logic [DIV_W-1:0]  tickCnt;
  logic [EOP_W-1:0]  eopCnt;
  logic [1:0]        modeQ;

  logic              driving;
  logic              modeChange;
  logic              rawQ;
  logic              busy;
  logic              stuffNow;
  logic              needByte;
  logic              endData;
  logic              eopMore;
  logic [DIV_W-1:0]  divSel;
  logic [DIV_W:0]    tickNext;

  always_comb begin
    driving    = ~opMode[0];
    modeChange = (opMode != modeQ);
    rawQ       = (modeQ == MODE_RAW);
    divSel     = speedSel ? DIV_W'(FS_DIV) : DIV_W'(HS_DIV);
    busy       = (state != ST_IDLE);
    tickNext   = {1'b0, tickCnt} + 1'b1;
    symTick    = busy && !modeChange && (tickNext >= {1'b0, divSel});
    stuffNow   = symTick && (state == ST_DATA) && !rawQ && stuffDue;
    needByte   = symTick && (state == ST_DATA) && !stuffNow && bitsDone;
    inReady    = needByte;
    endData    = needByte && !inValid;
    eopMore    = (eopCnt < EOP_W'(EOP_SE0));

    strobe.arm       = (state == ST_IDLE) && txStart && driving && !modeChange;
    strobe.loadByte  = needByte && inValid;
    strobe.emitData  = symTick && (state == ST_DATA) && !stuffNow && !bitsDone;
    strobe.emitStuff = stuffNow;
    strobe.emitSe0   = (endData && !rawQ) || (symTick && (state == ST_EOP) && eopMore);
    strobe.emitJ     = (endData && rawQ) || (symTick && (state == ST_EOP) && !eopMore);
    strobe.abort     = modeChange;
    strobe.rawMode   = rawQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      eopCnt  <= '0;
      modeQ   <= MODE_OFF;
      driveEn <= 1'b0;
    end else begin
      modeQ   <= opMode;
      driveEn <= driving;
      if (modeChange) begin
        state   <= ST_IDLE;
        tickCnt <= '0;
        eopCnt  <= '0;
      end else begin
        if (!busy || symTick) tickCnt <= '0;
        else                  tickCnt <= tickCnt + 1'b1;
        unique case (state)
          ST_IDLE: if (strobe.arm) state <= ST_DATA;
          ST_DATA: if (endData) begin
            state  <= rawQ ? ST_IDLE : ST_EOP;
            eopCnt <= EOP_W'(1);
          end
          ST_EOP: if (symTick) begin
            if (eopMore) eopCnt <= eopCnt + 1'b1;
            else         state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // A byte request never repeats on the following cycle
  assert_ready_single_R4: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !inReady);

  // Byte requests only happen while the line is driven
  assert_ready_driven_R7: assert property (@(posedge clk) disable iff (rst)
    inReady |-> driveEn);

  // A non-driving code releases the line at the next edge
  assert_mode_off_R8: assert property (@(posedge clk) disable iff (rst)
    opMode[0] |=> (!driveEn && !inReady));

endmodule

// File: rtl/usbTxDatapath.sv
module usbTxDatapath
  import usbTxPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  txStrobe_t         strobe,
  output logic              bitsDone,
  output logic              stuffDue,
  output logic [1:0]        lineSym
);

  localparam int CNT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitsLeft;
  logic [ONES_W-1:0] onesCnt;
  logic              lineLvl;   // 1 = J level

  logic curBit;
  logic emitBit;
  logic nrzLvl;

  function automatic logic [1:0] symOf(input logic lvl);
    return lvl ? SYM_J : SYM_K;
  endfunction

  always_comb begin
    curBit   = strobe.loadByte ? inData[0] : shiftReg[0];
    emitBit  = strobe.loadByte || strobe.emitData;
    nrzLvl   = curBit ? lineLvl : ~lineLvl;
    bitsDone = (bitsLeft == '0);
    stuffDue = (onesCnt == ONES_W'(STUFF_RUN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bitsLeft <= '0;
      onesCnt  <= '0;
      lineLvl  <= 1'b1;
      lineSym  <= SYM_J;
    end else if (strobe.abort || strobe.arm) begin
      bitsLeft <= '0;
      onesCnt  <= '0;
      lineLvl  <= 1'b1;
      if (strobe.abort) lineSym <= SYM_J;
    end else begin
      if (strobe.loadByte) begin
        shiftReg <= inData >> 1;
        bitsLeft <= CNT_W'(DATA_W - 1);
      end else if (strobe.emitData) begin
        shiftReg <= shiftReg >> 1;
        bitsLeft <= bitsLeft - 1'b1;
      end

      if (emitBit) begin
        if (strobe.rawMode) begin
          lineSym <= curBit ? SYM_J : SYM_K;
        end else begin
          lineLvl <= nrzLvl;
          lineSym <= symOf(nrzLvl);
          onesCnt <= curBit ? onesCnt + 1'b1 : '0;
        end
      end else if (strobe.emitStuff) begin
        lineLvl <= ~lineLvl;
        lineSym <= symOf(~lineLvl);
        onesCnt <= '0;
      end else if (strobe.emitSe0) begin
        lineSym <= SYM_SE0;
      end else if (strobe.emitJ) begin
        lineSym <= SYM_J;
        lineLvl <= 1'b1;
      end
    end
  end

  // A stuffed zero always changes the line symbol
  assert_stuff_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.emitStuff |=> (lineSym != $past(lineSym)));

  // Ones counter never runs past the stuffing threshold
  assert_ones_bound_R3: assert property (@(posedge clk) disable iff (rst)
    onesCnt <= ONES_W'(STUFF_RUN));

endmodule

// File: rtl/usbTxEncoder.sv
module usbTxEncoder
  import usbTxPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int HS_DIV    = 1,
  parameter int FS_DIV    = 4,
  parameter int EOP_SE0   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              txStart,
  input  logic [1:0]        opMode,
  input  logic              speedSel,
  output logic              lineDp,
  output logic              lineDm,
  output logic              driveEn
);

  txStrobe_t  strobe;
  logic       bitsDone;
  logic       stuffDue;
  logic       symTick;
  logic [1:0] lineSym;

  usbTxCtrl #(
    .HS_DIV (HS_DIV),
    .FS_DIV (FS_DIV),
    .EOP_SE0(EOP_SE0)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .txStart (txStart),
    .inValid (inValid),
    .opMode  (opMode),
    .speedSel(speedSel),
    .bitsDone(bitsDone),
    .stuffDue(stuffDue),
    .inReady (inReady),
    .driveEn (driveEn),
    .symTick (symTick),
    .strobe  (strobe)
  );

  usbTxDatapath #(
    .DATA_W   (DATA_W),
    .STUFF_RUN(STUFF_RUN)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .inData  (inData),
    .strobe  (strobe),
    .bitsDone(bitsDone),
    .stuffDue(stuffDue),
    .lineSym (lineSym)
  );

  assign {lineDp, lineDm} = driveEn ? lineSym : SYM_SE0;

  // Symbols change only on a symbol-rate tick or a mode change
  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (rst)
    (!symTick && !strobe.abort) |=> $stable(lineSym));

endmodule

// File: tb/tb_usbTxEncoder.sv
module tb_usbTxEncoder;

  localparam logic [1:0] J = 2'b10, K = 2'b01, SE0 = 2'b00;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] inData;
  logic       inValid;
  logic       inReady;
  logic       txStart;
  logic [1:0] opMode;
  logic       speedSel;
  logic       lineDp, lineDm, driveEn;

  int errors = 0;
  int checks = 0;

  logic [1:0] expQ[$];
  logic [7:0] pkt[4];
  int         pktLen;

  always #2 clk = ~clk;

  usbTxEncoder dut (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inReady(inReady),
    .txStart(txStart), .opMode(opMode), .speedSel(speedSel),
    .lineDp(lineDp), .lineDm(lineDm), .driveEn(driveEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference coding from the requirements
  task automatic buildExpected(input logic raw);
    logic lvl;
    int   ones;
    lvl  = 1'b1;
    ones = 0;
    expQ.delete();
    for (int i = 0; i < pktLen; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic bitV;
        bitV = pkt[i][b];
        if (raw) begin
          expQ.push_back(bitV ? J : K);
        end else begin
          if (!bitV) lvl = ~lvl;
          ones = bitV ? ones + 1 : 0;
          expQ.push_back(lvl ? J : K);
          if (ones == 6) begin
            lvl  = ~lvl;
            ones = 0;
            expQ.push_back(lvl ? J : K);
          end
        end
      end
    end
    if (raw) expQ.push_back(J);
    else begin
      expQ.push_back(SE0);
      expQ.push_back(SE0);
      expQ.push_back(J);
    end
  endtask

  task automatic runPacket(input string req, input logic raw);
    int period;
    period = speedSel ? 4 : 1;
    buildExpected(raw);
    @(negedge clk);
    txStart = 1'b1;
    fork
      begin : driver
        @(posedge clk);
        #1 txStart = 1'b0;
        for (int i = 0; i < pktLen; i++) begin
          inData  = pkt[i];
          inValid = 1'b1;
          @(negedge clk);
          while (!inReady) @(negedge clk);
          @(posedge clk);
          #1;
        end
        inValid = 1'b0;
      end
      begin : monitor
        logic [1:0] exp;
        @(posedge clk);
        while (expQ.size() > 0) begin
          repeat (period) @(posedge clk);
          @(negedge clk);
          exp = expQ.pop_front();
          check({lineDp, lineDm} == exp && driveEn, req, "line symbol",
                {driveEn, lineDp, lineDm}, {1'b1, exp});
        end
      end
    join
    repeat (6) @(negedge clk);
    check({lineDp, lineDm} == J && !inReady, "R5", "idle after packet",
          {inReady, lineDp, lineDm}, {1'b0, J});
  endtask

  task automatic setMode(input logic [1:0] m);
    @(negedge clk);
    opMode = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; inData = '0; inValid = 1'b0; txStart = 1'b0;
    opMode = 2'b00; speedSel = 1'b0;
    repeat (3) @(negedge clk);
    check(!driveEn && !lineDp && !lineDm && !inReady, "R1", "reset outputs",
          {driveEn, lineDp, lineDm, inReady}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(driveEn && {lineDp, lineDm} == J, "R8", "drive after reset release",
          {driveEn, lineDp, lineDm}, {1'b1, J});
    @(negedge clk);

    // Normal mode, high speed
    pktLen = 2; pkt[0] = 8'h00; pkt[1] = 8'hA5;
    runPacket("R2", 1'b0);
    pktLen = 3; pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h80;
    runPacket("R3", 1'b0);
    pktLen = 1; pkt[0] = 8'hFC;
    runPacket("R5", 1'b0);
    pktLen = 2; pkt[0] = 8'h01; pkt[1] = 8'h80;
    runPacket("R4", 1'b0);

    // Normal mode, full speed
    speedSel = 1'b1;
    pktLen = 2; pkt[0] = 8'h7E; pkt[1] = 8'hFF;
    runPacket("R9", 1'b0);
    speedSel = 1'b0;

    // Raw mode
    setMode(2'b10);
    pktLen = 3; pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h0F;
    runPacket("R6", 1'b1);
    speedSel = 1'b1;
    pktLen = 1; pkt[0] = 8'h3C;
    runPacket("R9", 1'b1);
    speedSel = 1'b0;

    // Non-driving codes ignore start requests
    for (int m = 1; m < 4; m += 2) begin
      setMode(2'(m));
      check(!driveEn && !lineDp && !lineDm, "R7", "non-driving lines",
            {driveEn, lineDp, lineDm}, 0);
      txStart = 1'b1; inValid = 1'b1; inData = 8'h55;
      @(negedge clk);
      txStart = 1'b0;
      for (int c = 0; c < 20; c++) begin
        check(!inReady && !driveEn && !lineDp && !lineDm, "R7", "start ignored",
              {inReady, driveEn, lineDp, lineDm}, 0);
        @(negedge clk);
      end
      inValid = 1'b0;
    end

    // Mode change in the middle of a packet
    setMode(2'b00);
    txStart = 1'b1; inValid = 1'b1; inData = 8'h00;
    @(negedge clk);
    txStart = 1'b0;
    repeat (4) @(negedge clk);
    opMode = 2'b01;
    @(negedge clk);
    check(!driveEn && !lineDp && !lineDm && !inReady, "R8", "abort releases line",
          {driveEn, lineDp, lineDm, inReady}, 0);
    opMode = 2'b00;
    @(negedge clk);
    check(driveEn && {lineDp, lineDm} == J, "R8", "idle J after re-enable",
          {driveEn, lineDp, lineDm}, {1'b1, J});
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      check(!inReady && {lineDp, lineDm} == J, "R8", "no resumed packet",
            {inReady, lineDp, lineDm}, {1'b0, J});
    end
    inValid = 1'b0;

    // Normal packet still works after the abort
    pktLen = 1; pkt[0] = 8'hC3;
    runPacket("R2", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule